// File: doc/BRIEF.md
# Seven-Instruction Register Core

A minimal processor core that executes one 8-bit instruction per clock cycle, drawn from a fixed set of seven: port input, port output, register copy, addition, subtraction, bitwise AND and bitwise OR. It holds four 8-bit registers, and it can read four input ports and drive four output ports. Instructions come from an external sequencer on `instr` and are qualified by `instr_vld`. The core has no program counter, no instruction memory and no flags.

Each instruction has three fields. The opcode sits in bits [7:4]. Bits [3:2] name the destination register, or for a port write the output port. Bits [1:0] name the source register, or for a port read the input port. The decoder sorts each opcode into one of eight named operations: OP_IN, OP_OUT, OP_MOV, OP_ADD, OP_SUB, OP_AND, OP_OR and OP_NOP. From that operation it derives a control word. The control word says whether the register file is written and where the written data comes from: an input port, the source register, or the ALU result. It also says whether an output port is loaded. Data movement never passes through the ALU. Arithmetic and logic results always replace the destination register. The core keeps no control state between instructions, so every instruction takes exactly one cycle.

Top module: `mcu7_core`

## Requirements
- R1: An instruction acts only in a cycle where `instr_vld` is high. The fields are opcode = bits [7:4], d = bits [3:2] and s = bits [1:0]. When `instr_vld` is low, no register and no output port changes.
- R2: Opcode 0000 (IN) loads input port s into register d.
- R3: Opcode 0001 (OUT) loads register s into output port d. One edge after the instruction is captured, `out_wr` has only bit d set for exactly one cycle. The other output ports do not change.
- R4: Opcode 0010 (MOV) copies register s into register d.
- R5: Opcode 0011 (ADD) writes (d + s) mod 256 into register d.
- R6: Opcode 0100 (SUB) writes (d - s) mod 256 into register d. The operand order is always destination minus source.
- R7: Opcode 0101 (AND) writes d & s into register d. Opcode 0110 (OR) writes d | s into register d.
- R8: Opcodes 0111 through 1111 change no register and no output port, and they raise no strobe.
- R9: A synchronous reset clears all four registers, all four output ports and `out_wr` to zero.
- R10: An output port keeps its value until the next OUT to that same port.
- R11: A register written by an instruction already holds the new value for the instruction issued in the next cycle. Only the destination register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| instr_vld | input | 1 | Qualifies `instr` for this cycle |
| instr | input | 8 | Instruction word: opcode [7:4], d [3:2], s [1:0] |
| in_port | input | 32 | Four input ports, port k at bits [8k+7:8k] |
| out_port | output | 32 | Four registered output ports, port k at bits [8k+7:8k] |
| out_wr | output | 4 | One-cycle write strobe per output port |

## Verification
A register result is due at the rising edge that captures its instruction, so an instruction issued in the very next cycle can already read it. An OUT result appears on `out_port` and `out_wr` after that same edge, so it is visible in the cycle that follows. Registers have no port of their own, so register contents are observed by issuing OUT instructions. When the driver issues an OUT, it stamps each expected item with the cycle in which the result is due. The monitor samples at the falling edge. It flags any strobe that arrives with no expected item, any item whose cycle stamp does not match, and any item still waiting after its due cycle.

// File: rtl/mcu7_pkg.sv
package mcu7_pkg;
    localparam int OPC_W  = 4;
    localparam int SEL_W  = 2;
    localparam int INSN_W = OPC_W + 2 * SEL_W;
    localparam int NREG   = 1 << SEL_W;
    localparam int NPORT  = 1 << SEL_W;

    typedef enum logic [2:0] {
        OP_IN, OP_OUT, OP_MOV, OP_ADD, OP_SUB, OP_AND, OP_OR, OP_NOP
    } op_e;

    typedef enum logic [1:0] {
        ALU_ADD, ALU_SUB, ALU_AND, ALU_OR
    } alu_op_e;

    typedef enum logic [1:0] {
        WSRC_PORT, WSRC_REG, WSRC_ALU
    } wsrc_e;

    typedef struct packed {
        op_e              op;
        logic             rf_we;
        wsrc_e            wsrc;
        alu_op_e          alu_op;
        logic             port_we;
        logic [SEL_W-1:0] dst;
        logic [SEL_W-1:0] src;
    } ctl_t;
endpackage

// File: rtl/mcu7_decode.sv
module mcu7_decode
    import mcu7_pkg::*;
(
    input  logic              vld,
    input  logic [INSN_W-1:0] insn,
    output ctl_t              ctl
);
    logic [OPC_W-1:0] opc;
    op_e              op;

    assign opc = insn[INSN_W-1 -: OPC_W];

    always_comb begin
        if (!vld) begin
            op = OP_NOP;
        end else begin
            unique case (opc)
                4'h0:    op = OP_IN;
                4'h1:    op = OP_OUT;
                4'h2:    op = OP_MOV;
                4'h3:    op = OP_ADD;
                4'h4:    op = OP_SUB;
                4'h5:    op = OP_AND;
                4'h6:    op = OP_OR;
                default: op = OP_NOP;
            endcase
        end
    end

    always_comb begin
        ctl         = '0;
        ctl.op      = op;
        ctl.dst     = insn[2*SEL_W-1 -: SEL_W];
        ctl.src     = insn[SEL_W-1:0];
        ctl.wsrc    = WSRC_ALU;
        ctl.alu_op  = ALU_ADD;
        unique case (op)
            OP_IN:   begin ctl.rf_we = 1'b1; ctl.wsrc = WSRC_PORT; end
            OP_OUT:  ctl.port_we = 1'b1;
            OP_MOV:  begin ctl.rf_we = 1'b1; ctl.wsrc = WSRC_REG; end
            OP_ADD:  begin ctl.rf_we = 1'b1; ctl.alu_op = ALU_ADD; end
            OP_SUB:  begin ctl.rf_we = 1'b1; ctl.alu_op = ALU_SUB; end
            OP_AND:  begin ctl.rf_we = 1'b1; ctl.alu_op = ALU_AND; end
            OP_OR:   begin ctl.rf_we = 1'b1; ctl.alu_op = ALU_OR;  end
            default: ;
        endcase
    end
endmodule

// File: rtl/mcu7_alu.sv
module mcu7_alu
    import mcu7_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           alu_op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        unique case (alu_op)
            ALU_ADD: y = a + b;
            ALU_SUB: y = a - b;
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            default: y = '0;
        endcase
    end

    // R6: destination minus source, checked by adding the source back
    always_comb begin
        if (alu_op == ALU_SUB) begin
            assert_sub_order_R6: assert (DATA_W'(y + b) == a);
        end
    end
endmodule

// File: rtl/mcu7_regfile.sv
module mcu7_regfile
    import mcu7_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SEL_W-1:0]  raddr_a,
    input  logic [SEL_W-1:0]  raddr_b,
    output logic [DATA_W-1:0] rdata_a,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[waddr] <= wdata;
        end
    end

    assign rdata_a = regs[raddr_a];
    assign rdata_b = regs[raddr_b];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_chk
            // R11: only the addressed register takes a write
            assert_unaddr_kept_R11: assert property (@(posedge clk) disable iff (rst)
                (we && waddr != SEL_W'(g)) |=> $stable(regs[g]));
            // R8: no write enable, no register change
            assert_idle_kept_R8: assert property (@(posedge clk) disable iff (rst)
                !we |=> $stable(regs[g]));
        end
    endgenerate
endmodule

// File: rtl/mcu7_outports.sv
module mcu7_outports
    import mcu7_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    we,
    input  logic [SEL_W-1:0]        sel,
    input  logic [DATA_W-1:0]       wdata,
    output logic [NPORT*DATA_W-1:0] port_q,
    output logic [NPORT-1:0]        wr_q
);
    generate
        for (genvar g = 0; g < NPORT; g++) begin : g_port
            always_ff @(posedge clk) begin
                if (rst) begin
                    port_q[g*DATA_W +: DATA_W] <= '0;
                    wr_q[g]                    <= 1'b0;
                end else begin
                    wr_q[g] <= we && (sel == SEL_W'(g));
                    if (we && (sel == SEL_W'(g))) port_q[g*DATA_W +: DATA_W] <= wdata;
                end
            end

            // R10: a port without a strobe keeps its value
            assert_port_hold_R10: assert property (@(posedge clk) disable iff (rst)
                !wr_q[g] |-> $stable(port_q[g*DATA_W +: DATA_W]));
        end
    endgenerate

    // R3: never more than one strobe
    assert_strobe_onehot_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_q));
endmodule

// File: rtl/mcu7_core.sv
module mcu7_core
    import mcu7_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    instr_vld,
    input  logic [INSN_W-1:0]       instr,
    input  logic [NPORT*DATA_W-1:0] in_port,
    output logic [NPORT*DATA_W-1:0] out_port,
    output logic [NPORT-1:0]        out_wr
);
    ctl_t              ctl;
    logic [DATA_W-1:0] rd_a, rd_b, alu_y, rf_wdata, in_sel;

    mcu7_decode u_dec (
        .vld  (instr_vld),
        .insn (instr),
        .ctl  (ctl)
    );

    mcu7_regfile #(.DATA_W(DATA_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .we      (ctl.rf_we),
        .waddr   (ctl.dst),
        .wdata   (rf_wdata),
        .raddr_a (ctl.dst),
        .raddr_b (ctl.src),
        .rdata_a (rd_a),
        .rdata_b (rd_b)
    );

    mcu7_alu #(.DATA_W(DATA_W)) u_alu (
        .alu_op (ctl.alu_op),
        .a      (rd_a),
        .b      (rd_b),
        .y      (alu_y)
    );

    assign in_sel = in_port[ctl.src*DATA_W +: DATA_W];

    always_comb begin
        unique case (ctl.wsrc)
            WSRC_PORT: rf_wdata = in_sel;
            WSRC_REG:  rf_wdata = rd_b;
            default:   rf_wdata = alu_y;
        endcase
    end

    mcu7_outports #(.DATA_W(DATA_W)) u_out (
        .clk    (clk),
        .rst    (rst),
        .we     (ctl.port_we),
        .sel    (ctl.dst),
        .wdata  (rd_b),
        .port_q (out_port),
        .wr_q   (out_wr)
    );

    // R1: no strobe follows an unqualified cycle
    assert_ignore_unqualified_R1: assert property (@(posedge clk) disable iff (rst)
        !instr_vld |=> (out_wr == '0));
    // R8: unused opcodes raise no strobe
    assert_nop_silent_R8: assert property (@(posedge clk) disable iff (rst)
        (instr_vld && instr[INSN_W-1 -: OPC_W] > 4'h6) |=> (out_wr == '0));
    // R9: state is clear in the first cycle after reset
    assert_reset_clear_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_wr == '0 && out_port == '0));
endmodule

// File: tb/tb_mcu7_core.sv
module tb_mcu7_core;
    localparam logic [3:0] C_IN = 4'h0, C_OUT = 4'h1, C_MOV = 4'h2, C_ADD = 4'h3,
                           C_SUB = 4'h4, C_AND = 4'h5, C_OR = 4'h6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        instr_vld = 1'b0;
    logic [7:0]  instr = '0;
    logic [31:0] in_port = '0;
    logic [31:0] out_port;
    logic [3:0]  out_wr;

    mcu7_core dut (
        .clk(clk), .rst(rst), .instr_vld(instr_vld), .instr(instr),
        .in_port(in_port), .out_port(out_port), .out_wr(out_wr)
    );

    always #4 clk = ~clk;

    typedef struct {
        int        port;
        logic [7:0] val;
        int        due;
        string     tag;
    } exp_t;

    exp_t       q[$];
    logic [7:0] mdl [4];
    logic [7:0] last_out [4];
    int         checks = 0;
    int         errors = 0;
    int         cyc = 0;
    bit         mon_on = 1'b0;
    bit         done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic iss(input logic [3:0] op, input logic [1:0] d, input logic [1:0] s,
                       input string tag, input bit v = 1'b1);
        @(negedge clk);
        instr     = {op, d, s};
        instr_vld = v;
        if (v) begin
            case (op)
                C_IN:  mdl[d] = in_port[s*8 +: 8];
                C_OUT: begin
                    q.push_back('{port: d, val: mdl[s], due: cyc + 1, tag: tag});
                    last_out[d] = mdl[s];
                end
                C_MOV: mdl[d] = mdl[s];
                C_ADD: mdl[d] = mdl[d] + mdl[s];
                C_SUB: mdl[d] = mdl[d] - mdl[s];
                C_AND: mdl[d] = mdl[d] & mdl[s];
                C_OR:  mdl[d] = mdl[d] | mdl[s];
                default: ;
            endcase
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            instr_vld = 1'b0;
            instr     = '0;
        end
    endtask

    task automatic dump_all(input string tag);
        for (int r = 0; r < 4; r++) iss(C_OUT, 2'(r), 2'(r), tag);
    endtask

    // monitor: compares each strobe against the scoreboard
    always @(negedge clk) begin
        if (mon_on) begin
            if (out_wr != 4'b0) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R8 unexpected strobe", 32'(out_wr), 32'h0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(out_wr == 4'(1 << e.port), {e.tag, " strobe"}, 32'(out_wr), 32'(1 << e.port));
                    chk(out_port[e.port*8 +: 8] == e.val, {e.tag, " data"},
                        32'(out_port[e.port*8 +: 8]), 32'(e.val));
                    chk(cyc == e.due, {e.tag, " timing R3"}, 32'(cyc), 32'(e.due));
                end
            end else if (q.size() != 0 && q[0].due < cyc) begin
                exp_t e;
                e = q.pop_front();
                chk(1'b0, {e.tag, " missing strobe R3"}, 32'(cyc), 32'(e.due));
            end
        end
    end

    initial begin
        for (int r = 0; r < 4; r++) begin mdl[r] = '0; last_out[r] = '0; end
        repeat (3) @(negedge clk);
        chk(out_port == 32'h0, "R9 ports cleared", out_port, 32'h0);
        chk(out_wr == 4'h0, "R9 strobes cleared", 32'(out_wr), 32'h0);
        rst = 1'b0;
        mon_on = 1'b1;
        dump_all("R9");

        in_port = {8'hF0, 8'h80, 8'h7F, 8'h05};
        for (int r = 0; r < 4; r++) iss(C_IN, 2'(r), 2'(r), "R2");
        dump_all("R2");
        iss(C_IN, 2'd0, 2'd3, "R2");
        iss(C_OUT, 2'd1, 2'd0, "R2");

        iss(C_MOV, 2'd0, 2'd1, "R4");
        iss(C_OUT, 2'd0, 2'd0, "R4");

        iss(C_ADD, 2'd1, 2'd2, "R5");
        iss(C_OUT, 2'd1, 2'd1, "R5");
        iss(C_ADD, 2'd3, 2'd2, "R5");
        iss(C_OUT, 2'd3, 2'd3, "R5");

        iss(C_SUB, 2'd0, 2'd2, "R6");
        iss(C_OUT, 2'd0, 2'd0, "R6");
        iss(C_MOV, 2'd2, 2'd3, "R6");
        iss(C_SUB, 2'd2, 2'd1, "R6");
        iss(C_OUT, 2'd2, 2'd2, "R6");
        iss(C_SUB, 2'd3, 2'd3, "R6");
        iss(C_OUT, 2'd3, 2'd3, "R6");

        in_port = {8'h3C, 8'hA5, 8'h0F, 8'hC3};
        for (int r = 0; r < 4; r++) iss(C_IN, 2'(r), 2'(r), "R2");
        iss(C_AND, 2'd0, 2'd1, "R7");
        iss(C_OR,  2'd2, 2'd3, "R7");
        dump_all("R7");

        for (int c = 7; c < 16; c++) iss(4'(c), 2'(c % 4), 2'((c + 1) % 4), "R8");
        dump_all("R8");

        iss(C_MOV, 2'd0, 2'd3, "R1", 1'b0);
        iss(C_OUT, 2'd2, 2'd1, "R1", 1'b0);
        iss(C_IN,  2'd1, 2'd2, "R1", 1'b0);
        idle(2);
        dump_all("R1");

        iss(C_IN,  2'd3, 2'd1, "R11");
        iss(C_ADD, 2'd3, 2'd3, "R11");
        iss(C_OUT, 2'd1, 2'd3, "R11");
        dump_all("R11");

        iss(C_OUT, 2'd2, 2'd0, "R10");
        iss(C_OUT, 2'd0, 2'd3, "R10");
        iss(C_ADD, 2'd2, 2'd2, "R10");
        iss(C_OUT, 2'd1, 2'd2, "R10");
        idle(4);
        for (int p = 0; p < 4; p++)
            chk(out_port[p*8 +: 8] == last_out[p], "R10 port hold",
                32'(out_port[p*8 +: 8]), 32'(last_out[p]));

        idle(2);
        chk(q.size() == 0, "R3 scoreboard drained", 32'(q.size()), 32'h0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule